// File: doc/BRIEF.md
# Single-Operand Negate, Clear and Complement Unit

This unit carries out four one-operand data operations for an integer execution stage: negate, negate with the extend bit subtracted as well, clear, and bitwise complement. Each works on a byte, word or long lane of a 32-bit operand. The unit returns the new destination value and a new five-bit condition code set. It also reports whether the size code was unusable, and how many bus cycles the operation costs. Effective address work and memory traffic belong to the surrounding datapath. A single input says whether the operand came from memory, and that input only affects the cycle cost.

All inputs are sampled on every rising clock edge. The results appear on registered outputs one edge later, so a new operation can be issued each cycle. Only the selected lane of the destination changes. Bits above the lane are passed through from the operand, so the caller can write the full register back.

Top module: `ncc_unit`

## Requirements
- R1: Negate-with-extend (op code 00) produces (0 − lane − X) in the selected lane. C and X are both set when the lane is nonzero or X was set. N is the lane's top bit. V is set when the operand's top bit and the result's top bit are both 1.
- R2: Negate-with-extend clears Z when the lane result is nonzero and otherwise leaves Z as it was on the flag input, so Z never goes from 0 to 1.
- R3: Clear (op code 01) gives a zero lane and sets N,V,C to 0 and Z to 1, whatever the operand; X is unchanged.
- R4: Negate (op code 10) produces (0 − lane). N is the result's top bit and Z is set when the lane is zero. V is set only when the operand lane is the most negative value. C and X are both set when the operand lane is nonzero.
- R5: Complement (op code 11) inverts the lane. N and Z follow the result, V and C are cleared, and X is unchanged.
- R6: Size code 00 selects bits 7:0, 01 selects 15:0 and 10 selects 31:0. Operand bits above the lane appear unchanged in the result.
- R7: The cycle count is 4 for byte or word and 6 for long, and it doubles when the memory indicator is 1.
- R8: Size code 11 raises the illegal-size output. The result then equals the operand, the flags equal the flag input and the cycle count is 0. For every valid size the illegal-size output is 0.
- R9: While reset is asserted, every output is zero. Otherwise the outputs reflect the inputs present at the previous rising edge.

Flag vectors are packed as bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_kind | input | 2 | 00 negate-with-extend, 01 clear, 10 negate, 11 complement |
| size_code | input | 2 | 00 byte, 01 word, 10 long, 11 illegal |
| operand | input | 32 | Source and destination value |
| flags_in | input | 5 | Current condition codes {X,N,Z,V,C} |
| in_memory | input | 1 | 1 when the operand lives in memory |
| result | output | 32 | Destination value after the operation |
| flags_out | output | 5 | New condition codes {X,N,Z,V,C} |
| bad_size | output | 1 | Size code 11 was presented |
| cycles | output | 4 | Cycle cost of the operation |

## Verification
The bench targets the sticky zero flag of negate-with-extend. It pairs a zero lane and a clear X with both values of the incoming Z: a design that computed Z afresh would set a Z that was clear. Most-negative lanes at each width test overflow, and a design that took V from the wrong bit position would miss it. Operands with live upper bits catch a design that zero-extends or sign-extends the destination. Clear is applied to all-ones operands, and the illegal size code is applied to every operation, to catch a design that lets the operand or a computed flag leak through.

// File: rtl/ncc_pkg.sv
package ncc_pkg;
    localparam int DATA_W  = 32;
    localparam int FLAG_W  = 5;
    localparam int CYC_W   = 4;

    typedef enum logic [1:0] {
        OPK_NEGX = 2'b00,
        OPK_CLR  = 2'b01,
        OPK_NEG  = 2'b10,
        OPK_NOT  = 2'b11
    } opk_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } sz_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        ccr_t              flags;
        logic              bad;
        logic [CYC_W-1:0]  cycles;
    } ncc_out_t;
endpackage

// File: rtl/ncc_lane.sv
module ncc_lane
    import ncc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [1:0]   size_code,
    output logic [W-1:0] lane_mask,
    output logic [W-1:0] sign_bit,
    output logic         size_ok
);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    always_comb begin
        lane_mask = '0;
        size_ok   = 1'b1;
        unique case (sz_e'(size_code))
            SZ_BYTE: lane_mask[BYTE_W-1:0] = '1;
            SZ_WORD: lane_mask[WORD_W-1:0] = '1;
            SZ_LONG: lane_mask             = '1;
            default: size_ok               = 1'b0;
        endcase
        sign_bit = lane_mask ^ (lane_mask >> 1);
    end
endmodule

// File: rtl/ncc_core.sv
module ncc_core
    import ncc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [1:0]   op_kind,
    input  logic [W-1:0] operand,
    input  ccr_t         flags_in,
    input  logic [W-1:0] lane_mask,
    input  logic [W-1:0] sign_bit,
    output logic [W-1:0] result,
    output ccr_t         flags_out
);
    logic [W-1:0] src_m;
    logic [W:0]   diff;
    logic [W-1:0] lane_v;
    logic         x_used;
    logic         src_top;
    logic         res_top;
    logic         res_zero;

    always_comb begin
        src_m    = operand & lane_mask;
        x_used   = (opk_e'(op_kind) == OPK_NEGX) ? flags_in.x : 1'b0;
        diff     = {1'b0, {W{1'b0}}} - {1'b0, src_m} - {{W{1'b0}}, x_used};
        src_top  = |(src_m & sign_bit);
        lane_v   = '0;
        flags_out = flags_in;
        unique case (opk_e'(op_kind))
            OPK_NEGX, OPK_NEG: lane_v = diff[W-1:0];
            OPK_CLR:           lane_v = '0;
            OPK_NOT:           lane_v = ~src_m;
            default:           lane_v = '0;
        endcase
        lane_v   = lane_v & lane_mask;
        res_top  = |(lane_v & sign_bit);
        res_zero = (lane_v == '0);

        unique case (opk_e'(op_kind))
            OPK_NEGX: begin
                flags_out.c = (src_m != '0) | x_used;
                flags_out.x = (src_m != '0) | x_used;
                flags_out.n = res_top;
                flags_out.v = src_top & res_top;
                flags_out.z = res_zero ? flags_in.z : 1'b0;
            end
            OPK_NEG: begin
                flags_out.c = (src_m != '0);
                flags_out.x = (src_m != '0);
                flags_out.n = res_top;
                flags_out.v = src_top & res_top;
                flags_out.z = res_zero;
            end
            OPK_CLR: begin
                flags_out.n = 1'b0;
                flags_out.z = 1'b1;
                flags_out.v = 1'b0;
                flags_out.c = 1'b0;
            end
            OPK_NOT: begin
                flags_out.n = res_top;
                flags_out.z = res_zero;
                flags_out.v = 1'b0;
                flags_out.c = 1'b0;
            end
            default: flags_out = flags_in;
        endcase
        result = (operand & ~lane_mask) | lane_v;
    end
endmodule

// File: rtl/ncc_cost.sv
module ncc_cost
    import ncc_pkg::*;
#(
    parameter int SHORT_COST = 4,
    parameter int LONG_COST  = 6
) (
    input  logic [1:0]       size_code,
    input  logic             in_memory,
    output logic [CYC_W-1:0] cycles
);
    localparam logic [CYC_W-1:0] SHORT_C = CYC_W'(SHORT_COST);
    localparam logic [CYC_W-1:0] LONG_C  = CYC_W'(LONG_COST);

    logic [CYC_W-1:0] base;

    always_comb begin
        unique case (sz_e'(size_code))
            SZ_BYTE, SZ_WORD: base = SHORT_C;
            SZ_LONG:          base = LONG_C;
            default:          base = '0;
        endcase
        cycles = in_memory ? (base << 1) : base;
    end
endmodule

// File: rtl/ncc_unit.sv
module ncc_unit
    import ncc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        size_code,
    input  logic [DATA_W-1:0] operand,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              in_memory,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              bad_size,
    output logic [3:0]        cycles
);
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] sign_bit;
    logic              size_ok;
    logic [DATA_W-1:0] core_res;
    ccr_t              core_flags;
    logic [CYC_W-1:0]  cost;
    ncc_out_t          out_d;
    ncc_out_t          out_q;

    ncc_lane #(.W(DATA_W)) u_lane (
        .size_code (size_code),
        .lane_mask (lane_mask),
        .sign_bit  (sign_bit),
        .size_ok   (size_ok)
    );

    ncc_core #(.W(DATA_W)) u_core (
        .op_kind   (op_kind),
        .operand   (operand),
        .flags_in  (ccr_t'(flags_in)),
        .lane_mask (lane_mask),
        .sign_bit  (sign_bit),
        .result    (core_res),
        .flags_out (core_flags)
    );

    ncc_cost u_cost (
        .size_code (size_code),
        .in_memory (in_memory),
        .cycles    (cost)
    );

    always_comb begin
        out_d = out_q;
        if (size_ok) begin
            out_d.result = core_res;
            out_d.flags  = core_flags;
            out_d.bad    = 1'b0;
            out_d.cycles = cost;
        end else begin
            out_d.result = operand;
            out_d.flags  = ccr_t'(flags_in);
            out_d.bad    = 1'b1;
            out_d.cycles = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result    = out_q.result;
    assign flags_out = out_q.flags;
    assign bad_size  = out_q.bad;
    assign cycles    = out_q.cycles;
endmodule

// File: rtl/ncc_unit_chk.sv
module ncc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  op_kind,
    input logic [1:0]  size_code,
    input logic [31:0] operand,
    input logic [4:0]  flags_in,
    input logic        in_memory,
    input logic [31:0] result,
    input logic [4:0]  flags_out,
    input logic        bad_size,
    input logic [3:0]  cycles
);
    a_r2_negx_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'b00 && size_code != 2'b11 && !flags_in[2]) |=> !flags_out[2]);

    a_r3_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'b01 && size_code != 2'b11)
        |=> (flags_out[3:0] == 4'b0100 && flags_out[4] == $past(flags_in[4])));

    a_r5_not_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'b11 && size_code != 2'b11)
        |=> (flags_out[1:0] == 2'b00 && flags_out[4] == $past(flags_in[4])));

    a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 2'b00) |=> (result[31:8] == $past(operand[31:8])));

    a_r7_long_mem_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 2'b10 && in_memory) |=> (cycles == 4'd12));

    a_r8_bad_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 2'b11) |=> (bad_size && result == $past(operand)
                                  && flags_out == $past(flags_in) && cycles == 4'd0));

    a_r8_good_size: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code != 2'b11) |=> !bad_size);
endmodule

bind ncc_unit ncc_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_kind   (op_kind),
    .size_code (size_code),
    .operand   (operand),
    .flags_in  (flags_in),
    .in_memory (in_memory),
    .result    (result),
    .flags_out (flags_out),
    .bad_size  (bad_size),
    .cycles    (cycles)
);

// File: tb/tb_ncc_unit.sv
module tb_ncc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [1:0]  size_code = 2'b00;
    logic [31:0] operand = 32'h0;
    logic [4:0]  flags_in = 5'h0;
    logic        in_memory = 1'b0;
    logic [31:0] result;
    logic [4:0]  flags_out;
    logic        bad_size;
    logic [3:0]  cycles;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ncc_unit dut (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .size_code(size_code),
        .operand(operand), .flags_in(flags_in), .in_memory(in_memory),
        .result(result), .flags_out(flags_out), .bad_size(bad_size), .cycles(cycles)
    );

    logic [31:0] e_res;
    logic [4:0]  e_flg;
    logic        e_bad;
    logic [3:0]  e_cyc;

    task automatic model();
        int w;
        logic [31:0] m, s, r, top;
        logic x, n, z, v, c;
        e_bad = (size_code == 2'b11);
        if (e_bad) begin
            e_res = operand; e_flg = flags_in; e_cyc = 0;
            return;
        end
        w   = (size_code == 2'b00) ? 8 : (size_code == 2'b01) ? 16 : 32;
        m   = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        top = 32'h1 << (w - 1);
        s   = operand & m;
        {x, n, z, v, c} = flags_in;
        case (op_kind)
            2'b00: begin
                r = (32'h0 - s - {31'h0, flags_in[4]}) & m;
                c = (s != 0) || flags_in[4]; x = c;
                n = (r & top) != 0;
                v = ((s & top) != 0) && ((r & top) != 0);
                if (r != 0) z = 1'b0;
            end
            2'b01: begin r = 0; n = 0; z = 1; v = 0; c = 0; end
            2'b10: begin
                r = (32'h0 - s) & m;
                c = (s != 0); x = c;
                n = (r & top) != 0; z = (r == 0); v = (s == top);
            end
            default: begin
                r = ~s & m; n = (r & top) != 0; z = (r == 0); v = 0; c = 0;
            end
        endcase
        e_res = (operand & ~m) | r;
        e_flg = {x, n, z, v, c};
        e_cyc = ((w == 32) ? 4'd6 : 4'd4) << (in_memory ? 1 : 0);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (op=%b sz=%b opnd=%h fl=%b)",
                     tag, act, exp, op_kind, size_code, operand, flags_in);
        end
    endtask

    function automatic string res_tag();
        if (size_code == 2'b11) return "R8 result";
        case (op_kind)
            2'b00: return "R1 result";
            2'b01: return "R3 result";
            2'b10: return "R4 result";
            default: return "R5 result";
        endcase
    endfunction

    task automatic run(logic [1:0] op, logic [1:0] sz, logic [31:0] v,
                       logic [4:0] fl, logic mem);
        op_kind = op; size_code = sz; operand = v; flags_in = fl; in_memory = mem;
        model();
        @(negedge clk);
        chk(res_tag(), result, e_res);
        chk((op == 2'b00) ? "R2 flags" : "R6 flags", {27'h0, flags_out}, {27'h0, e_flg});
        chk("R7 cycles", {28'h0, cycles}, {28'h0, e_cyc});
        chk("R8 bad_size", {31'h0, bad_size}, {31'h0, e_bad});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        operand = 32'hDEAD_BEEF; flags_in = 5'h1F; size_code = 2'b10;
        repeat (3) @(negedge clk);
        // R9: reset holds outputs at zero
        chk("R9 reset result", result, 32'h0);
        chk("R9 reset flags", {27'h0, flags_out}, 32'h0);
        chk("R9 reset cycles", {28'h0, cycles, bad_size}, 32'h0);
        rst_n = 1'b1;
        // R2: zero lane with X clear keeps Z both ways
        run(2'b00, 2'b00, 32'hAB00_1200, 5'b00100, 1'b0);
        run(2'b00, 2'b00, 32'hAB00_1200, 5'b00000, 1'b0);
        run(2'b00, 2'b01, 32'h0000_0000, 5'b10100, 1'b1);
        // R1/R4: most negative lanes
        run(2'b10, 2'b00, 32'h1234_5680, 5'b00000, 1'b0);
        run(2'b10, 2'b01, 32'hFFFF_8000, 5'b11111, 1'b1);
        run(2'b10, 2'b10, 32'h8000_0000, 5'b00000, 1'b0);
        run(2'b00, 2'b00, 32'h0000_0080, 5'b10000, 1'b0);
        run(2'b10, 2'b10, 32'h0000_0000, 5'b11011, 1'b1);
        // R3: clear on all ones, R6 upper bits kept
        run(2'b01, 2'b00, 32'hFFFF_FFFF, 5'b11011, 1'b1);
        run(2'b01, 2'b01, 32'hFFFF_FFFF, 5'b01011, 1'b0);
        run(2'b01, 2'b10, 32'hFFFF_FFFF, 5'b10000, 1'b1);
        // R5: complement
        run(2'b11, 2'b00, 32'h5555_55FF, 5'b10011, 1'b0);
        run(2'b11, 2'b10, 32'h0000_0000, 5'b00111, 1'b1);
        // R8: illegal size for each op
        for (int k = 0; k < 4; k++)
            run(2'(k), 2'b11, 32'hC0FF_EE00 + k, 5'(k * 7), k[0]);
        // random mix
        for (int i = 0; i < 400; i++)
            run(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom(),
                5'($urandom()), 1'($urandom()));
        // R9: reset again clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset result again", result, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule